// File: doc/BRIEF.md
# Eight-Channel Timer Bank Register Front End

This block is the 32-bit memory-mapped front end of a bank of eight down-counting timer channels. A simple request port (valid, write, byte address, byte enables, write data) reaches per-channel count, reload and two match registers, a shared control word and a secondary control word. Read data and an error flag come back one clock after the request. The eight channel counters are instantiated inside as simple children.

The shared control word gives each channel a nibble holding a run enable, a clock-source select, an overflow-interrupt enable and a pulse-mode enable. When that word is written, the block does not apply the new nibbles in one step. Channels being switched off stop at once. The new clock, interrupt and pulse settings follow one clock later. Channels being switched on start one clock after that, with their counters loaded from the reload register at that moment. Pulse mode is refused on the four lowest channels. The channel windows sit on both sides of the control words, so the address map has a hole.

Top module: `tmrbank_regs`

## Requirements
- R1: While reset is asserted, and after it is released, both control words read as zero and every run, clock-select, interrupt-enable and pulse output is zero.
- R2: A read returns `rsp_valid` high with its data exactly one clock after the request. `rsp_valid` stays low after writes and in idle cycles.
- R3: Channels 0–2 sit at byte offsets 0x00, 0x10 and 0x20. Channels 3–7 sit at 0x40, 0x50, 0x60, 0x70 and 0x80. Within a channel, +0x0 is the live count, +0x4 the reload value, +0x8 match A and +0xC match B.
- R4: The shared control word is at 0x30. A secondary control word at 0x34 is readable and writable and has no effect on any channel.
- R5: Offsets 0x38 and 0x3C, offsets from 0x90 up, any offset with bits [1:0] non-zero, and any access whose byte enables are not all ones are illegal. Reads return zero, writes change nothing, and `bus_err` is high for one clock, one clock after the request.
- R6: Channel i owns control bits [4i+3:4i]. Bit 4i is run enable, 4i+1 selects the external tick (0 = every bus clock), 4i+2 is overflow-interrupt enable and 4i+3 is pulse enable.
- R7: When a control write clears a running channel's enable, its run output falls on the clock of the write. Its other settings change one clock later.
- R8: When a control write sets a stopped channel's enable, its other settings change one clock after the write. Its run output rises one clock after that, and the counter is loaded from the reload register on the same clock.
- R9: A pulse-enable bit written for channels 0–3 (bits 3, 7, 11, 15) is stored as zero, never drives `chan_pulse`, and raises `bus_err` one clock after the write. Channels 4–7 accept it.
- R10: A running channel decrements once per bus clock, or once per `ext_tick` strobe when the external tick is selected. It reloads instead of decrementing when the count is zero.
- R11: A write to a channel's count register loads it while the channel is running and is ignored while it is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | One-clock strobe from the external slow time base |
| req_valid | input | 1 | Access request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_be | input | 4 | Byte enables; only 4'hF is legal |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one clock after a read |
| rsp_rdata | output | 32 | Read data |
| bus_err | output | 1 | One-clock pulse for an illegal access or refused pulse bit |
| chan_run | output | 8 | Applied run enable per channel |
| chan_extclk | output | 8 | Applied external-tick select per channel |
| chan_ovfie | output | 8 | Applied overflow-interrupt enable per channel |
| chan_pulse | output | 8 | Applied pulse enable per channel |

## Verification
The ordering inside a single control write is the hardest part to observe. The intermediate states last only one clock and sit between two writes, so the bench samples every clock after the write. It checks that a stopping channel has already stopped while its new settings are still the old ones, and that a starting channel has its new settings one clock before its run output rises. Counter loading at the start point is made exact by selecting the external tick and holding the strobe low, which freezes the count so that it can be read back. The bus-clock count is then checked separately with back-to-back reads that land on consecutive edges.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;
  localparam int NUM_CH       = 8;
  localparam int CH_W         = $clog2(NUM_CH);
  localparam int CTL_BITS     = 4;
  localparam int CTL_W        = NUM_CH * CTL_BITS;
  localparam int ADDR_W       = 12;
  localparam int DATA_W       = 32;
  localparam int BE_W         = DATA_W / 8;
  localparam int PULSE_MIN_CH = 4;

  localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_CTRL2   = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_HI_BASE = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_HI_END  = 12'h090;

  localparam int F_EN    = 0;
  localparam int F_EXT   = 1;
  localparam int F_OVF   = 2;
  localparam int F_PULSE = 3;

  typedef enum logic [1:0] {TGT_CHAN, TGT_CTRL, TGT_CTRL2, TGT_NONE} tgt_e;
  typedef enum logic [1:0] {CREG_COUNT, CREG_RELOAD, CREG_MATCH_A, CREG_MATCH_B} creg_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_CFG, SEQ_EN} seq_e;

  typedef struct packed {
    tgt_e            tgt;
    logic [CH_W-1:0] ch;
    creg_e           creg;
  } dec_t;

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] addr,
                                       input logic [BE_W-1:0]   be);
    dec_t       d;
    logic [3:0] blk;
    d.tgt  = TGT_NONE;
    d.ch   = '0;
    d.creg = CREG_COUNT;
    blk    = addr[7:4] - 4'd1;
    if (be == {BE_W{1'b1}} && addr[1:0] == 2'b00) begin
      if (addr < OFF_CTRL) begin
        d.tgt  = TGT_CHAN;
        d.ch   = CH_W'(addr[5:4]);
        d.creg = creg_e'(addr[3:2]);
      end else if (addr == OFF_CTRL) begin
        d.tgt = TGT_CTRL;
      end else if (addr == OFF_CTRL2) begin
        d.tgt = TGT_CTRL2;
      end else if (addr >= OFF_HI_BASE && addr < OFF_HI_END) begin
        d.tgt  = TGT_CHAN;
        d.ch   = blk[CH_W-1:0];
        d.creg = creg_e'(addr[3:2]);
      end
    end
    return d;
  endfunction

  function automatic logic [CTL_W-1:0] pulse_forbidden();
    logic [CTL_W-1:0] m;
    m = '0;
    for (int i = 0; i < PULSE_MIN_CH; i++) m[i*CTL_BITS + F_PULSE] = 1'b1;
    return m;
  endfunction

  function automatic logic [NUM_CH-1:0] field_of(input logic [CTL_W-1:0] w,
                                                 input int f);
    logic [NUM_CH-1:0] v;
    for (int i = 0; i < NUM_CH; i++) v[i] = w[i*CTL_BITS + f];
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] next_count(input logic [DATA_W-1:0] cnt,
                                                   input logic [DATA_W-1:0] rl);
    return (cnt == '0) ? rl : cnt - 1'b1;
  endfunction
endpackage

// File: rtl/tmrbank_chan.sv
module tmrbank_chan
  import tmrbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              tick,
  input  logic              wr,
  input  creg_e             wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] match_a,
  output logic [DATA_W-1:0] match_b
);
  logic count_wr;
  assign count_wr = wr && (wr_reg == CREG_COUNT) && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload  <= '0;
      match_a <= '0;
      match_b <= '0;
    end else if (wr) begin
      case (wr_reg)
        CREG_RELOAD:  reload  <= wr_data;
        CREG_MATCH_A: match_a <= wr_data;
        CREG_MATCH_B: match_b <= wr_data;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (start)         count <= reload;
    else if (count_wr)      count <= wr_data;
    else if (run && tick)   count <= next_count(count, reload);
  end
endmodule

// File: rtl/tmrbank_ctrlseq.sv
module tmrbank_ctrlseq
  import tmrbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTL_W-1:0]  word,
  output logic [NUM_CH-1:0] run,
  output logic [NUM_CH-1:0] ext,
  output logic [NUM_CH-1:0] ovf,
  output logic [NUM_CH-1:0] pulse,
  output logic [NUM_CH-1:0] start
);
  seq_e              st;
  logic [CTL_W-1:0]  pend;
  logic              step_cfg;
  logic              step_en;
  logic [NUM_CH-1:0] pend_en;

  assign step_cfg = (st == SEQ_CFG) && !wr;
  assign step_en  = (st == SEQ_EN)  && !wr;
  assign pend_en  = field_of(pend, F_EN);
  assign start    = step_en ? (pend_en & ~run) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SEQ_IDLE;
      pend  <= '0;
      run   <= '0;
      ext   <= '0;
      ovf   <= '0;
      pulse <= '0;
    end else if (wr) begin
      run  <= run & field_of(word, F_EN);
      pend <= word;
      st   <= SEQ_CFG;
    end else if (step_cfg) begin
      ext   <= field_of(pend, F_EXT);
      ovf   <= field_of(pend, F_OVF);
      pulse <= field_of(pend, F_PULSE);
      st    <= SEQ_EN;
    end else if (step_en) begin
      run <= pend_en;
      st  <= SEQ_IDLE;
    end
  end
endmodule

// File: rtl/tmrbank_regs.sv
module tmrbank_regs
  import tmrbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_err,
  output logic [NUM_CH-1:0] chan_run,
  output logic [NUM_CH-1:0] chan_extclk,
  output logic [NUM_CH-1:0] chan_ovfie,
  output logic [NUM_CH-1:0] chan_pulse
);
  dec_t              dec;
  logic              addr_bad;
  logic              ctrl_wr;
  logic              pulse_err;
  logic [CTL_W-1:0]  ctrl_masked;
  logic [CTL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0] ctrl2_q;
  logic [DATA_W-1:0] rd_val;
  logic [NUM_CH-1:0] start;

  logic [DATA_W-1:0] cnt_a [NUM_CH];
  logic [DATA_W-1:0] rl_a  [NUM_CH];
  logic [DATA_W-1:0] ma_a  [NUM_CH];
  logic [DATA_W-1:0] mb_a  [NUM_CH];

  assign dec         = decode_addr(req_addr, req_be);
  assign addr_bad    = req_valid && (dec.tgt == TGT_NONE);
  assign ctrl_wr     = req_valid && req_write && (dec.tgt == TGT_CTRL);
  assign pulse_err   = ctrl_wr && |(req_wdata[CTL_W-1:0] & pulse_forbidden());
  assign ctrl_masked = req_wdata[CTL_W-1:0] & ~pulse_forbidden();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ctrl2_q <= '0;
    end else if (req_valid && req_write) begin
      if (dec.tgt == TGT_CTRL)  ctrl_q  <= ctrl_masked;
      if (dec.tgt == TGT_CTRL2) ctrl2_q <= req_wdata;
    end
  end

  tmrbank_ctrlseq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctrl_wr),
    .word  (ctrl_masked),
    .run   (chan_run),
    .ext   (chan_extclk),
    .ovf   (chan_ovfie),
    .pulse (chan_pulse),
    .start (start)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_wr;
    logic ch_tick;
    assign ch_wr   = req_valid && req_write && (dec.tgt == TGT_CHAN) &&
                     (dec.ch == CH_W'(i));
    assign ch_tick = chan_extclk[i] ? ext_tick : 1'b1;
    tmrbank_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (chan_run[i]),
      .start   (start[i]),
      .tick    (ch_tick),
      .wr      (ch_wr),
      .wr_reg  (dec.creg),
      .wr_data (req_wdata),
      .count   (cnt_a[i]),
      .reload  (rl_a[i]),
      .match_a (ma_a[i]),
      .match_b (mb_a[i])
    );
  end

  always_comb begin
    rd_val = '0;
    case (dec.tgt)
      TGT_CHAN: begin
        case (dec.creg)
          CREG_COUNT:   rd_val = cnt_a[dec.ch];
          CREG_RELOAD:  rd_val = rl_a[dec.ch];
          CREG_MATCH_A: rd_val = ma_a[dec.ch];
          default:      rd_val = mb_a[dec.ch];
        endcase
      end
      TGT_CTRL:  rd_val = DATA_W'(ctrl_q);
      TGT_CTRL2: rd_val = ctrl2_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_val : '0;
      bus_err   <= addr_bad || pulse_err;
    end
  end
endmodule

// File: rtl/tmrbank_regs_chk.sv
module tmrbank_regs_chk
  import tmrbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ext_tick,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BE_W-1:0]   req_be,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_err,
  input logic [NUM_CH-1:0] chan_run,
  input logic [NUM_CH-1:0] chan_extclk,
  input logic [NUM_CH-1:0] chan_ovfie,
  input logic [NUM_CH-1:0] chan_pulse
);
  logic hole_rd;
  logic low_pulse_wr;
  assign hole_rd = req_valid && !req_write &&
                   (req_addr == 12'h038 || req_addr == 12'h03C);
  assign low_pulse_wr = req_valid && req_write && req_addr == 12'h030 &&
                        req_be == 4'hF &&
                        (req_wdata[3] | req_wdata[7] | req_wdata[11] | req_wdata[15]);

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid) else $error("read not answered"); // R2
  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write)) else $error("stray response"); // R2
  AST_HOLE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == 12'h038) |=> bus_err) else $error("hole not flagged"); // R5
  AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hole_rd |=> (rsp_rdata == '0)) else $error("hole read nonzero"); // R5
  AST_LOW_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    low_pulse_wr |=> bus_err) else $error("low pulse not flagged"); // R9
  AST_STOP_BEFORE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(chan_run) & ~chan_run)) |-> $stable({chan_extclk, chan_ovfie, chan_pulse}))
    else $error("config changed with stop"); // R7
  AST_CFG_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chan_run & ~$past(chan_run))) |-> $stable({chan_extclk, chan_ovfie, chan_pulse}))
    else $error("config changed with start"); // R8
endmodule

bind tmrbank_regs tmrbank_regs_chk u_chk (.*);

// File: tb/sim_tmrbank_regs.sv
module sim_tmrbank_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        bus_err;
  logic [7:0]  chan_run, chan_extclk, chan_ovfie, chan_pulse;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmrbank_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] base(input int i);
    return (i < 3) ? 12'(i*16) : 12'(12'h040 + (i-3)*16);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic [3:0] be, output logic err);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_be = 4'hF;
    err = bus_err;
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] be,
                    output logic [31:0] d, output logic err, output logic vld);
    req_valid = 1; req_write = 0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 0; req_be = 4'hF;
    d = rsp_rdata; err = bus_err; vld = rsp_valid;
  endtask

  task automatic ctrl_clear();
    logic e;
    wr(12'h030, 32'h0, 4'hF, e);
    repeat (2) @(negedge clk);
  endtask

  task automatic tick();
    ext_tick = 1;
    @(negedge clk);
    ext_tick = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e, v;
    chk("R1 run in reset", {24'h0, chan_run}, 32'h0);
    chk("R1 cfg in reset", {8'h0, chan_extclk, chan_ovfie, chan_pulse}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    rd(12'h030, 4'hF, d, e, v); chk("R1 ctrl after reset", d, 32'h0);
    rd(12'h034, 4'hF, d, e, v); chk("R1 ctrl2 after reset", d, 32'h0);
  endtask

  task automatic t_handshake();
    logic [31:0] d; logic e, v;
    wr(12'h004, 32'h1234, 4'hF, e);
    chk("R2 no rsp after write", {31'h0, rsp_valid}, 32'h0);
    rd(12'h004, 4'hF, d, e, v);
    chk("R2 rsp_valid after read", {31'h0, v}, 32'h1);
    chk("R2 read data", d, 32'h1234);
    @(negedge clk);
    chk("R2 rsp_valid drops", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d; logic e, v;
    for (int i = 0; i < 8; i++) wr(base(i) + 12'h4, 32'h100 + i, 4'hF, e);
    for (int i = 0; i < 8; i++) begin
      rd(base(i) + 12'h4, 4'hF, d, e, v);
      chk("R3 reload per channel", d, 32'h100 + i);
    end
    wr(12'h08C, 32'hCAFE0007, 4'hF, e);
    wr(12'h028, 32'hBEEF0002, 4'hF, e);
    rd(12'h08C, 4'hF, d, e, v); chk("R3 ch7 match B", d, 32'hCAFE0007);
    rd(12'h028, 4'hF, d, e, v); chk("R3 ch2 match A", d, 32'hBEEF0002);
    rd(12'h02C, 4'hF, d, e, v); chk("R3 ch2 match B untouched", d, 32'h0);
  endtask

  task automatic t_ctrl2();
    logic [31:0] d; logic e, v;
    wr(12'h034, 32'hFFFF_FFFF, 4'hF, e);
    repeat (3) @(negedge clk);
    chk("R4 ctrl2 no effect on run", {24'h0, chan_run}, 32'h0);
    rd(12'h034, 4'hF, d, e, v); chk("R4 ctrl2 readback", d, 32'hFFFF_FFFF);
    rd(12'h030, 4'hF, d, e, v); chk("R4 ctrl untouched", d, 32'h0);
  endtask

  task automatic t_illegal();
    logic [31:0] d; logic e, v;
    wr(12'h038, 32'h1, 4'hF, e); chk("R5 write 0x38 err", {31'h0, e}, 32'h1);
    rd(12'h038, 4'hF, d, e, v);
    chk("R5 read 0x38 zero", d, 32'h0); chk("R5 read 0x38 err", {31'h0, e}, 32'h1);
    @(negedge clk); chk("R5 err one clock", {31'h0, bus_err}, 32'h0);
    wr(12'h03C, 32'h5, 4'hF, e); chk("R5 write 0x3C err", {31'h0, e}, 32'h1);
    rd(12'h034, 4'hF, d, e, v); chk("R5 0x3C write ignored", d, 32'hFFFF_FFFF);
    wr(12'h006, 32'h77, 4'hF, e); chk("R5 misaligned err", {31'h0, e}, 32'h1);
    wr(12'h004, 32'h88, 4'h3, e); chk("R5 partial be err", {31'h0, e}, 32'h1);
    rd(12'h004, 4'hF, d, e, v); chk("R5 bad writes ignored", d, 32'h100);
    rd(12'h090, 4'hF, d, e, v);
    chk("R5 read 0x90 zero", d, 32'h0); chk("R5 read 0x90 err", {31'h0, e}, 32'h1);
  endtask

  task automatic t_fields();
    logic [31:0] d; logic e, v;
    ctrl_clear();
    wr(12'h030, 32'h0E00_0000, 4'hF, e);
    chk("R6 legal ctrl no err", {31'h0, e}, 32'h0);
    @(negedge clk);
    chk("R6 ch6 ext", {24'h0, chan_extclk}, 32'h40);
    chk("R6 ch6 ovf", {24'h0, chan_ovfie}, 32'h40);
    chk("R6 ch6 pulse", {24'h0, chan_pulse}, 32'h40);
    @(negedge clk);
    chk("R6 ch6 not running", {24'h0, chan_run}, 32'h0);
    rd(12'h030, 4'hF, d, e, v); chk("R6 ctrl readback", d, 32'h0E00_0000);
  endtask

  task automatic t_stop_order();
    logic e;
    ctrl_clear();
    wr(12'h030, 32'h10, 4'hF, e);
    repeat (2) @(negedge clk);
    chk("R7 ch1 running", {24'h0, chan_run}, 32'h02);
    wr(12'h030, 32'h40, 4'hF, e);
    chk("R7 stopped at write", {24'h0, chan_run}, 32'h0);
    chk("R7 ovf still old", {24'h0, chan_ovfie}, 32'h0);
    @(negedge clk);
    chk("R7 ovf applied next", {24'h0, chan_ovfie}, 32'h02);
  endtask

  task automatic t_start_order();
    logic [31:0] d; logic e, v;
    ctrl_clear();
    wr(12'h024, 32'h55, 4'hF, e);
    wr(12'h030, 32'h300, 4'hF, e);
    chk("R8 not yet ext", {24'h0, chan_extclk}, 32'h0);
    chk("R8 not yet run", {24'h0, chan_run}, 32'h0);
    @(negedge clk);
    chk("R8 ext first", {24'h0, chan_extclk}, 32'h04);
    chk("R8 run waits", {24'h0, chan_run}, 32'h0);
    @(negedge clk);
    chk("R8 run rises", {24'h0, chan_run}, 32'h04);
    rd(12'h020, 4'hF, d, e, v); chk("R8 count loaded", d, 32'h55);
  endtask

  task automatic t_count_ext();
    logic [31:0] d; logic e, v;
    ctrl_clear();
    wr(12'h064, 32'h5, 4'hF, e);
    wr(12'h030, 32'h0030_0000, 4'hF, e);
    repeat (2) @(negedge clk);
    rd(12'h060, 4'hF, d, e, v); chk("R10 ext start", d, 32'h5);
    tick();
    rd(12'h060, 4'hF, d, e, v); chk("R10 ext one tick", d, 32'h4);
    repeat (4) tick();
    rd(12'h060, 4'hF, d, e, v); chk("R10 ext at zero", d, 32'h0);
    tick();
    rd(12'h060, 4'hF, d, e, v); chk("R10 ext wraps to reload", d, 32'h5);
  endtask

  task automatic t_count_bus();
    logic [31:0] d; logic e, v;
    logic [31:0] expv [5] = '{32'h3, 32'h2, 32'h1, 32'h0, 32'h3};
    ctrl_clear();
    wr(12'h084, 32'h3, 4'hF, e);
    wr(12'h030, 32'h1000_0000, 4'hF, e);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      rd(12'h080, 4'hF, d, e, v);
      chk("R10 bus clock count", d, expv[k]);
    end
  endtask

  task automatic t_status();
    logic [31:0] d; logic e, v;
    ctrl_clear();
    wr(12'h054, 32'd10, 4'hF, e);
    wr(12'h030, 32'h0003_0000, 4'hF, e);
    repeat (2) @(negedge clk);
    wr(12'h050, 32'd7, 4'hF, e);
    rd(12'h050, 4'hF, d, e, v); chk("R11 count write while running", d, 32'd7);
    wr(12'h030, 32'h0002_0000, 4'hF, e);
    repeat (2) @(negedge clk);
    wr(12'h050, 32'd2, 4'hF, e);
    rd(12'h050, 4'hF, d, e, v); chk("R11 count write while stopped", d, 32'd7);
  endtask

  task automatic t_pulse();
    logic [31:0] d; logic e, v;
    ctrl_clear();
    wr(12'h030, 32'h0008_0008, 4'hF, e);
    chk("R9 low pulse flagged", {31'h0, e}, 32'h1);
    @(negedge clk);
    chk("R9 only ch4 pulse", {24'h0, chan_pulse}, 32'h10);
    rd(12'h030, 4'hF, d, e, v); chk("R9 low pulse stored zero", d, 32'h0008_0000);
    wr(12'h030, 32'h0008_0000, 4'hF, e);
    chk("R9 high pulse accepted", {31'h0, e}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_handshake();
    t_map();
    t_ctrl2();
    t_illegal();
    t_fields();
    t_stop_order();
    t_start_order();
    t_count_ext();
    t_count_bus();
    t_status();
    t_pulse();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule